// File: doc/BRIEF.md
# Audio serial clock generator

This block produces the serial bit clock and the left/right frame clock of a stereo audio link from a single master clock. A two-bit speed code selects how many master-clock cycles make up one frame: 512, 256 or 128. The bit clock always carries 64 periods per frame, so only the master-clock-to-bit-clock divide changes with the speed code.

A direction strap is sampled once after reset. When it is high, the block is clock master: it drives both clocks and asserts their output enables. When it is low, the block is clock slave: it leaves its outputs low and disabled, and takes the two clocks from outside through a two-flop synchronizer. It then measures every frame against the selected ratio and raises an error flag when a frame has the wrong length or the wrong number of bit clocks.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst_n` is low, and until the strap has been sampled, `bclk_o`, `lrck_o`, `bclk_oe`, `lrck_oe` and `ratio_err` are all 0.
- R2: The reset release passes through a two-stage synchronizer. `ms_strap` is sampled on the first master-clock edge after that internal release. A high strap sets master mode, with both output enables at 1. A low strap sets slave mode. Later changes of the strap have no effect until the next reset.
- R3: In master mode, with speed code 00 (single), 01 (double) or 10 (quad), `bclk_o` has a period of 8, 4 or 2 master clocks and a 50% duty cycle. Code 11 is treated as single.
- R4: In master mode, `lrck_o` spends 32 bit-clock periods low (left) and 32 high (right). It changes state only in the same cycle as a falling edge of `bclk_o`.
- R5: When `speed_sel` differs from the code in use, both dividers restart at the next master-clock edge with `bclk_o` and `lrck_o` low, which is the start of a left frame. The new ratio is used from then on, so in quad the first left half lasts 64 master clocks.
- R6: In slave mode, `bclk_oe` and `lrck_oe` are 0 and `bclk_o` and `lrck_o` stay 0. In master mode, `ratio_err` stays 0.
- R7: In slave mode, the master clocks between rising edges of the synchronized `lrck_in` are counted. At each rising edge after the first one, `ratio_err` is set when the count differs from 512, 256 or 128 for the selected code, and cleared when it matches.
- R8: In slave mode, `ratio_err` is also set at a frame edge when that frame did not hold exactly 64 rising edges of the synchronized `bclk_in`.
- R9: In slave mode, once a frame has been seen, `ratio_err` is set as soon as the count since the last `lrck_in` rising edge reaches the expected ratio without a new edge, without waiting for the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 as single |
| ms_strap | input | 1 | Direction strap, high selects master |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock |
| lrck_o | output | 1 | Generated frame clock, low for left |
| bclk_oe | output | 1 | Output enable for the bit clock pin |
| lrck_oe | output | 1 | Output enable for the frame clock pin |
| ratio_err | output | 1 | Slave-mode clock ratio error |

## Verification
The bench builds the block with its default parameters: 8 master clocks per single-speed bit clock and 64 bit clocks per frame. This gives the real 512/256/128 ratios and a quad-speed bit clock that toggles on every master clock, the tightest timing the divider has. These values make full frames short enough to measure several complete periods of both clocks in every mode. The slave stimulus covers matching, short, long and non-power-of-two frames, a frame with the wrong bit-clock count, and a stalled frame clock. Master runs cover all four speed codes, including the reserved one, and a speed change in the middle of a right half-frame.

// File: rtl/acg_pkg.sv
package acg_pkg;

  localparam logic [1:0] SPD_SINGLE = 2'b00;
  localparam logic [1:0] SPD_DOUBLE = 2'b01;
  localparam logic [1:0] SPD_QUAD   = 2'b10;

  // Right-shift applied to single-speed divide values; reserved code maps to single.
  function automatic int unsigned spd_shift(input logic [1:0] code);
    case (code)
      SPD_DOUBLE: spd_shift = 1;
      SPD_QUAD:   spd_shift = 2;
      default:    spd_shift = 0;
    endcase
  endfunction

endpackage

// File: rtl/acg_sync2.sv
module acg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/acg_ctrl.sv
module acg_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_strap,
  input  logic [1:0] speed_sel,
  output logic       rst_n_i,
  output logic       strap_done,
  output logic       run_master,
  output logic       run_slave,
  output logic [1:0] speed_q,
  output logic       restart
);

  logic rs1_q, rs2_q;
  logic done_q, done_n;
  logic mst_q, mst_n;
  logic [1:0] spd_q, spd_n;
  logic spd_en;

  // Reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign rst_n_i = rs2_q;

  // Strap capture: only while not yet done
  always_comb begin
    done_n = done_q;
    mst_n  = mst_q;
    if (!done_q) begin
      done_n = 1'b1;
      mst_n  = ms_strap;
    end
  end

  // Speed code tracking
  assign restart = done_q && (speed_sel != spd_q);
  assign spd_en  = !done_q || restart;

  always_comb begin
    spd_n = spd_q;
    if (spd_en) spd_n = speed_sel;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      done_q <= 1'b0;
      mst_q  <= 1'b0;
      spd_q  <= 2'b00;
    end else begin
      done_q <= done_n;
      mst_q  <= mst_n;
      spd_q  <= spd_n;
    end
  end

  assign strap_done = done_q;
  assign run_master = done_q && mst_q;
  assign run_slave  = done_q && !mst_q;
  assign speed_q    = spd_q;

endmodule

// File: rtl/acg_master_div.sv
module acg_master_div #(
  parameter int MCLK_PER_BCLK_SS = 8,
  parameter int BCLK_PER_FRAME   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] speed_q,
  output logic       bclk,
  output logic       lrck
);

  localparam int HALF_SS    = MCLK_PER_BCLK_SS / 2;
  localparam int CW         = (HALF_SS > 1) ? $clog2(HALF_SS) : 1;
  localparam int HALF_FRAME = BCLK_PER_FRAME / 2;
  localparam int BW         = (HALF_FRAME > 1) ? $clog2(HALF_FRAME) : 1;

  logic [CW-1:0] cnt_q, cnt_n, last_cnt;
  logic [BW-1:0] bit_q, bit_n;
  logic          bclk_q, bclk_n;
  logic          lrck_q, lrck_n;
  logic          half_done;

  always_comb last_cnt = CW'((HALF_SS >> acg_pkg::spd_shift(speed_q)) - 1);
  assign half_done = (cnt_q == last_cnt);

  always_comb begin
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    bclk_n = bclk_q;
    lrck_n = lrck_q;
    if (!run || restart) begin
      cnt_n  = '0;
      bit_n  = '0;
      bclk_n = 1'b0;
      lrck_n = 1'b0;
    end else if (half_done) begin
      cnt_n  = '0;
      bclk_n = !bclk_q;
      if (bclk_q) begin
        // falling edge of the bit clock
        if (bit_q == BW'(HALF_FRAME - 1)) begin
          bit_n  = '0;
          lrck_n = !lrck_q;
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      bclk_q <= bclk_n;
      lrck_q <= lrck_n;
    end
  end

  assign bclk = bclk_q;
  assign lrck = lrck_q;

endmodule

// File: rtl/acg_slave_mon.sv
module acg_slave_mon #(
  parameter int MCLK_PER_BCLK_SS = 8,
  parameter int BCLK_PER_FRAME   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] speed_q,
  input  logic       bclk_in,
  input  logic       lrck_in,
  output logic       ratio_err
);

  localparam int RATIO_MAX = MCLK_PER_BCLK_SS * BCLK_PER_FRAME;
  localparam int PW        = $clog2(RATIO_MAX) + 1;
  localparam int BCW       = $clog2(BCLK_PER_FRAME) + 2;

  logic [1:0]     sync_q;
  logic           bclk_s, lrck_s;
  logic           bclk_d_q, lrck_d_q;
  logic           lr_rise, bc_rise;
  logic [PW-1:0]  per_q, per_n, per_inc, ratio;
  logic [BCW-1:0] bc_q, bc_n, bc_tot;
  logic           armed_q, armed_n;
  logic           err_q, err_n;

  acg_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bclk_in, lrck_in}),
    .q     (sync_q)
  );

  assign bclk_s  = sync_q[1];
  assign lrck_s  = sync_q[0];
  assign lr_rise = lrck_s && !lrck_d_q;
  assign bc_rise = bclk_s && !bclk_d_q;

  always_comb ratio = PW'(RATIO_MAX >> acg_pkg::spd_shift(speed_q));

  always_comb begin
    per_inc = (per_q == {PW{1'b1}}) ? per_q : per_q + 1'b1;
    bc_tot  = (bc_q == {BCW{1'b1}}) ? bc_q : bc_q + BCW'(bc_rise);
  end

  always_comb begin
    per_n   = per_q;
    bc_n    = bc_q;
    armed_n = armed_q;
    err_n   = err_q;
    if (!run || restart) begin
      per_n   = '0;
      bc_n    = '0;
      armed_n = 1'b0;
      err_n   = 1'b0;
    end else if (lr_rise) begin
      per_n   = PW'(1);
      bc_n    = BCW'(bc_rise);
      armed_n = 1'b1;
      if (armed_q)
        err_n = (per_q != ratio) || (bc_tot != BCW'(BCLK_PER_FRAME));
    end else begin
      per_n = per_inc;
      bc_n  = bc_tot;
      if (armed_q && (per_q >= ratio)) err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d_q <= 1'b0;
      lrck_d_q <= 1'b0;
      per_q    <= '0;
      bc_q     <= '0;
      armed_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      bclk_d_q <= bclk_s;
      lrck_d_q <= lrck_s;
      per_q    <= per_n;
      bc_q     <= bc_n;
      armed_q  <= armed_n;
      err_q    <= err_n;
    end
  end

  assign ratio_err = err_q;

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int MCLK_PER_BCLK_SS = 8,
  parameter int BCLK_PER_FRAME   = 64
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       ms_strap,
  input  logic       bclk_in,
  input  logic       lrck_in,
  output logic       bclk_o,
  output logic       lrck_o,
  output logic       bclk_oe,
  output logic       lrck_oe,
  output logic       ratio_err
);

  logic       rst_n_i;
  logic       strap_done;
  logic       run_master;
  logic       run_slave;
  logic [1:0] speed_q;
  logic       div_restart;

  acg_ctrl u_ctrl (
    .clk        (mclk),
    .rst_n      (rst_n),
    .ms_strap   (ms_strap),
    .speed_sel  (speed_sel),
    .rst_n_i    (rst_n_i),
    .strap_done (strap_done),
    .run_master (run_master),
    .run_slave  (run_slave),
    .speed_q    (speed_q),
    .restart    (div_restart)
  );

  acg_master_div #(
    .MCLK_PER_BCLK_SS (MCLK_PER_BCLK_SS),
    .BCLK_PER_FRAME   (BCLK_PER_FRAME)
  ) u_div (
    .clk     (mclk),
    .rst_n   (rst_n_i),
    .run     (run_master),
    .restart (div_restart),
    .speed_q (speed_q),
    .bclk    (bclk_o),
    .lrck    (lrck_o)
  );

  acg_slave_mon #(
    .MCLK_PER_BCLK_SS (MCLK_PER_BCLK_SS),
    .BCLK_PER_FRAME   (BCLK_PER_FRAME)
  ) u_mon (
    .clk       (mclk),
    .rst_n     (rst_n_i),
    .run       (run_slave),
    .restart   (div_restart),
    .speed_q   (speed_q),
    .bclk_in   (bclk_in),
    .lrck_in   (lrck_in),
    .ratio_err (ratio_err)
  );

  assign bclk_oe = run_master;
  assign lrck_oe = run_master;

endmodule

// File: rtl/audio_clkgen_sva.sv
module audio_clkgen_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       bclk_o,
  input logic       lrck_o,
  input logic       bclk_oe,
  input logic       lrck_oe,
  input logic       ratio_err,
  input logic       strap_done,
  input logic       restart,
  input logic [1:0] speed_q
);

  // R1
  p_idle_before_strap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |-> (!bclk_oe && !lrck_oe && !bclk_o && !lrck_o && !ratio_err));

  // R2
  p_dir_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> ($stable(bclk_oe) && $stable(lrck_oe)));

  // R3
  p_quad_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_oe && !restart && speed_q == acg_pkg::SPD_QUAD) |=> (bclk_o != $past(bclk_o)));

  // R4
  p_frame_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_oe && !restart) |=> ((lrck_o == $past(lrck_o)) || (!bclk_o && $past(bclk_o))));

  // R6
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_oe |-> (!bclk_o && !lrck_o));

  // R6
  p_master_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_oe |-> !ratio_err);

endmodule

bind audio_clkgen audio_clkgen_sva u_sva (
  .clk        (mclk),
  .rst_n      (rst_n),
  .bclk_o     (bclk_o),
  .lrck_o     (lrck_o),
  .bclk_oe    (bclk_oe),
  .lrck_oe    (lrck_oe),
  .ratio_err  (ratio_err),
  .strap_done (strap_done),
  .restart    (div_restart),
  .speed_q    (speed_q)
);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 11;

  // {master, speed, frame length, bclk period, expected}
  // master: expected = bclk period in mclk; slave: expected = ratio_err
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 11'd0,   6'd0,  10'd8},
    {1'b1, 2'd1, 11'd0,   6'd0,  10'd4},
    {1'b1, 2'd2, 11'd0,   6'd0,  10'd2},
    {1'b1, 2'd3, 11'd0,   6'd0,  10'd8},
    {1'b0, 2'd0, 11'd512, 6'd8,  10'd0},
    {1'b0, 2'd1, 11'd256, 6'd4,  10'd0},
    {1'b0, 2'd2, 11'd128, 6'd2,  10'd0},
    {1'b0, 2'd0, 11'd256, 6'd4,  10'd1},
    {1'b0, 2'd2, 11'd512, 6'd8,  10'd1},
    {1'b0, 2'd1, 11'd384, 6'd6,  10'd1},
    {1'b0, 2'd0, 11'd512, 6'd16, 10'd1}
  };

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed_sel = 2'b00;
  logic       ms_strap = 1'b0;
  logic       bclk_in = 1'b0;
  logic       lrck_in = 1'b0;
  logic       bclk_o, lrck_o, bclk_oe, lrck_oe, ratio_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) mclk = ~mclk;

  audio_clkgen u_dut (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .speed_sel (speed_sel),
    .ms_strap  (ms_strap),
    .bclk_in   (bclk_in),
    .lrck_in   (lrck_in),
    .bclk_o    (bclk_o),
    .lrck_o    (lrck_o),
    .bclk_oe   (bclk_oe),
    .lrck_oe   (lrck_oe),
    .ratio_err (ratio_err)
  );

  always @(posedge mclk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap, input logic [1:0] spd);
    @(negedge mclk);
    rst_n = 1'b0;
    bclk_in = 1'b0;
    lrck_in = 1'b0;
    ms_strap = strap;
    speed_sel = spd;
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
    repeat (6) @(negedge mclk);
  endtask

  task automatic measure_master(output int bper, output int bhigh,
                                output int lper, output int lhigh, output int viol);
    int t, lb, ll, bh, lh;
    logic pb, pl;
    t = 0; lb = -1; ll = -1; bh = 0; lh = 0;
    bper = 0; bhigh = 0; lper = 0; lhigh = 0; viol = 0;
    @(negedge mclk);
    pb = bclk_o;
    pl = lrck_o;
    for (int i = 0; i < 2200; i++) begin
      @(negedge mclk);
      t++;
      if (bclk_o) bh++;
      else begin
        if (pb) bhigh = bh;
        bh = 0;
      end
      if (lrck_o) lh++;
      else begin
        if (pl) lhigh = lh;
        lh = 0;
      end
      if (bclk_o && !pb) begin
        if (lb >= 0) bper = t - lb;
        lb = t;
      end
      if (lrck_o && !pl) begin
        if (ll >= 0) lper = t - ll;
        ll = t;
      end
      if ((lrck_o != pl) && !(pb && !bclk_o)) viol++;
      pb = bclk_o;
      pl = lrck_o;
    end
  endtask

  task automatic drive_slave(input int n, input int bp, input int frames);
    for (int k = 0; k < n * frames; k++) begin
      @(negedge mclk);
      bclk_in = ((k % bp) >= (bp / 2));
      lrck_in = ((k % n) >= (n / 2));
    end
  endtask

  initial begin
    int bper, bhigh, lper, lhigh, viol, cnt;

    // Reset state (R1)
    rst_n = 1'b0;
    ms_strap = 1'b1;
    repeat (4) @(negedge mclk);
    check(!bclk_o && !lrck_o, "R1 clocks low in reset", {bclk_o, lrck_o}, 0);
    check(!bclk_oe && !lrck_oe, "R1 enables low in reset", {bclk_oe, lrck_oe}, 0);
    check(!ratio_err, "R1 error low in reset", ratio_err, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      logic       m;
      logic [1:0] spd;
      int n, bp, exp;
      m   = VEC[v][29];
      spd = VEC[v][28:27];
      n   = int'(VEC[v][26:16]);
      bp  = int'(VEC[v][15:10]);
      exp = int'(VEC[v][9:0]);
      do_reset(m, spd);
      if (m) begin
        check(bclk_oe && lrck_oe, "R2 master enables", {bclk_oe, lrck_oe}, 3);
        measure_master(bper, bhigh, lper, lhigh, viol);
        check(bper == exp, "R3 bclk period", bper, exp);
        check(bhigh == exp / 2, "R3 bclk high time", bhigh, exp / 2);
        check(lper == 64 * exp, "R4 lrck period", lper, 64 * exp);
        check(lhigh == 32 * exp, "R4 lrck high half", lhigh, 32 * exp);
        check(viol == 0, "R4 lrck moves on bclk fall", viol, 0);
        check(!ratio_err, "R6 no error in master", ratio_err, 0);
        ms_strap = 1'b0;
        repeat (20) @(negedge mclk);
        check(bclk_oe && lrck_oe, "R2 strap ignored after sampling", {bclk_oe, lrck_oe}, 3);
      end else begin
        check(!bclk_oe && !lrck_oe, "R6 slave enables low", {bclk_oe, lrck_oe}, 0);
        drive_slave(n, bp, 4);
        repeat (2) @(negedge mclk);
        check(!bclk_o && !lrck_o, "R6 slave outputs low", {bclk_o, lrck_o}, 0);
        if (bp == 16)
          check(ratio_err == exp[0], "R8 bit clock count per frame", ratio_err, exp);
        else
          check(ratio_err == exp[0], "R7 frame ratio check", ratio_err, exp);
      end
    end

    // Speed change mid right half (R5)
    do_reset(1'b1, 2'b00);
    while (!lrck_o) @(negedge mclk);
    repeat (37) @(negedge mclk);
    speed_sel = 2'b10;
    @(negedge mclk);
    check(!lrck_o && !bclk_o, "R5 restart at left frame start", {bclk_o, lrck_o}, 0);
    cnt = 0;
    while (!lrck_o && cnt < 1000) begin
      cnt++;
      @(negedge mclk);
    end
    check(cnt == 64, "R5 first left half after change", cnt, 64);
    measure_master(bper, bhigh, lper, lhigh, viol);
    check(bper == 2, "R5 new bclk period", bper, 2);

    // Stalled frame clock in slave (R9)
    do_reset(1'b0, 2'b00);
    drive_slave(512, 8, 2);
    repeat (200) @(negedge mclk);
    check(!ratio_err, "R9 no error within frame length", ratio_err, 0);
    repeat (400) @(negedge mclk);
    check(ratio_err, "R9 overrun flagged without edge", ratio_err, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule